// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block chooses, once per reset, whether the device starts in a debug monitor mode or in normal user mode. It watches the external reset pin together with the mode-select port pin, two high-voltage detect flags (one for the interrupt pin, one for the reset pin) and a flag that reports a blank reset vector. The choice is made when the external reset is released. After that moment the mode-select inputs may change freely, apart from a short qualification window that follows the release.

Once monitor mode is chosen, the block moves vector fetches to the alternate page and manages the watchdog disable. There are two ways into monitor mode. An entry caused by high voltage on the interrupt pin can be left with the external reset. An entry caused by a blank reset vector can be left only with a power-on reset. The block runs on the bus clock. Every pin-derived input first passes through a synchronizer of `SYNC_STAGES` flops (2 by default), so all timing below is counted from the synchronized values.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `por` is high and after it is released, `mon_mode`, `cop_dis` and `entry_fault` are 0 and `vec_page` is 0xFF. The mode stays undecided until the external reset rises.
- R2: The mode decision is made only on the bus-clock edge that sees the synchronized reset pin go from 0 to 1. Later changes of `irq_hv` or `vec_blank` do not alter the mode that was chosen.
- R3: At the decision edge, monitor mode is requested when `irq_hv` or `vec_blank` is 1. Otherwise the block settles in user mode with `mon_mode` = 0.
- R4: A requested entry fails if the mode-select pin is 1 at the decision edge or during any of the `WIN_CYCLES` (24) bus cycles that follow it. A failed entry gives `entry_fault` = 1 and user mode.
- R5: When the mode-select pin stays 0 through the whole window, monitor mode is kept with `entry_fault` = 0. From then on, the mode-select pin has no effect.
- R6: `vec_page` is 0xFE whenever `mon_mode` is 1, including during the window, and 0xFF at all other times.
- R7: A monitor entry made with `vec_blank` = 1 and `irq_hv` = 0 ignores the external reset going low. Only `por` clears it.
- R8: A monitor entry made with `irq_hv` = 1 is left when the synchronized external reset is 0. The block returns to the undecided state and decides again at the next rise.
- R9: `cop_dis` is 1 only in a monitor mode that was entered with `irq_hv` = 1, and only while the synchronized `irq_hv` is still 1 or reset-pin high voltage has been seen since entry.
- R10: Once `rst_hv` has been seen in such a monitor mode, `irq_hv` may fall while `cop_dis` stays 1. `cop_dis` is 0 in user mode and in a monitor mode entered through a blank vector.
- R11: `entry_fault` stays set until the next decision edge or `por`, and each of these clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_n | input | 1 | External reset pin level, active low |
| irq_hv | input | 1 | High voltage detected on the interrupt pin |
| rst_hv | input | 1 | High voltage detected on the reset pin |
| vec_blank | input | 1 | Reset vector reads as blank |
| mode_pin | input | 1 | Mode-select port pin level |
| mon_mode | output | 1 | Monitor mode active (window or confirmed) |
| cop_dis | output | 1 | Watchdog disable |
| entry_fault | output | 1 | Last monitor entry attempt failed |
| vec_page | output | 8 | High address byte used for vector fetches |

## Verification
The bench drives the mode-select pin high inside the window and exactly at the decision edge. A design that counts the window wrongly would either keep monitor mode after a late rise, or flag a fault for a rise that comes after the window has closed. It pulls the reset low after a blank-vector entry and after a high-voltage entry. A design that mixes up the two exit paths would either drop the locked mode or keep the other one. It also removes the interrupt-pin high voltage after reset-pin high voltage has been seen, where a design without the sticky flag would turn the watchdog back on. A long random phase compares every output with a behavioural model on every cycle, so the window boundaries and fault clearing are also checked against mixed timings.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_USER = 2'd1,
      ST_WIN  = 2'd2,
      ST_MON  = 2'd3
   } mon_state_e;

   function automatic logic is_mon(input mon_state_e s);
      return (s == ST_WIN) || (s == ST_MON);
   endfunction

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             por,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("mon_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] chain [STAGES];
         always_ff @(posedge clk or posedge por) begin
            if (por) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mon_window_cnt.sv
module mon_window_cnt #(
   parameter int WIN_CYCLES = 24,
   localparam int CNT_W     = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
   input  logic clk,
   input  logic por,
   input  logic clr,
   input  logic run,
   output logic done
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge por) begin
      if (por)                     cnt_q <= '0;
      else if (clr)                cnt_q <= '0;
      else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LAST);

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (por)
      cnt_q <= LAST);

   // R5
   cnt_clr_chk: assert property (@(posedge clk) disable iff (por)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/mon_entry_fsm.sv
module mon_entry_fsm
   import mon_entry_pkg::*;
(
   input  logic clk,
   input  logic por,
   input  logic s_rst,
   input  logic s_irq,
   input  logic s_rhv,
   input  logic s_mode,
   input  logic vec_blank,
   input  logic win_done,
   output logic win_clr,
   output logic win_run,
   output logic in_mon,
   output logic hv_entry,
   output logic rhv_seen,
   output logic fault
);

   mon_state_e st_q, st_d;
   logic rst_prev_q;
   logic hv_q, hv_d;
   logic blank_q, blank_d;
   logic fault_q, fault_d;
   logic rhv_q, rhv_d;
   logic rst_edge;
   logic locked;

   assign rst_edge = s_rst & ~rst_prev_q;
   assign locked   = blank_q & is_mon(st_q);

   always_comb begin
      st_d    = st_q;
      hv_d    = hv_q;
      blank_d = blank_q;
      fault_d = fault_q;
      if (!s_rst && !locked) begin
         st_d    = ST_IDLE;
         hv_d    = 1'b0;
         blank_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (rst_edge) begin
                  fault_d = 1'b0;
                  if (s_irq || vec_blank) begin
                     if (s_mode) begin
                        st_d    = ST_USER;
                        fault_d = 1'b1;
                     end else begin
                        st_d    = ST_WIN;
                        hv_d    = s_irq;
                        blank_d = ~s_irq;
                     end
                  end else begin
                     st_d = ST_USER;
                  end
               end
            end
            ST_WIN: begin
               if (s_mode) begin
                  st_d    = ST_USER;
                  fault_d = 1'b1;
                  hv_d    = 1'b0;
                  blank_d = 1'b0;
               end else if (win_done) begin
                  st_d = ST_MON;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (!is_mon(st_d))                   rhv_d = 1'b0;
      else if (is_mon(st_q) && hv_q && s_rhv) rhv_d = 1'b1;
      else                                 rhv_d = rhv_q;
   end

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         st_q       <= ST_IDLE;
         rst_prev_q <= 1'b0;
         hv_q       <= 1'b0;
         blank_q    <= 1'b0;
         fault_q    <= 1'b0;
         rhv_q      <= 1'b0;
      end else begin
         st_q       <= st_d;
         rst_prev_q <= s_rst;
         hv_q       <= hv_d;
         blank_q    <= blank_d;
         fault_q    <= fault_d;
         rhv_q      <= rhv_d;
      end
   end

   assign win_clr  = (st_q != ST_WIN);
   assign win_run  = (st_q == ST_WIN);
   assign in_mon   = is_mon(st_q);
   assign hv_entry = hv_q;
   assign rhv_seen = rhv_q;
   assign fault    = fault_q;

   // R7
   blank_lock_chk: assert property (@(posedge clk) disable iff (por)
      (st_q == ST_MON && blank_q) |=> (st_q == ST_MON));

   // R4
   fault_user_chk: assert property (@(posedge clk) disable iff (por)
      $rose(fault_q) |-> (st_q == ST_USER));

   // R2
   entry_edge_chk: assert property (@(posedge clk) disable iff (por)
      (st_q == ST_WIN && $past(st_q) == ST_IDLE) |-> $past(rst_edge));

   // R7
   entry_kind_chk: assert property (@(posedge clk) disable iff (por)
      in_mon |-> $countones({hv_q, blank_q}) == 1);

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl #(
   parameter int          SYNC_STAGES = 2,
   parameter int          WIN_CYCLES  = 24,
   parameter int          PAGE_W      = 8,
   parameter logic [7:0]  PAGE_USER   = 8'hFF,
   parameter logic [7:0]  PAGE_MON    = 8'hFE
) (
   input  logic              clk,
   input  logic              por,
   input  logic              rst_pin_n,
   input  logic              irq_hv,
   input  logic              rst_hv,
   input  logic              vec_blank,
   input  logic              mode_pin,
   output logic              mon_mode,
   output logic              cop_dis,
   output logic              entry_fault,
   output logic [PAGE_W-1:0] vec_page
);

   localparam int SYNC_W = 4;

   generate
      if (WIN_CYCLES < 2) begin : g_win_bad
         $error("mon_entry_ctrl: WIN_CYCLES must be at least 2");
      end
      if (PAGE_W != 8) begin : g_page_bad
         $error("mon_entry_ctrl: PAGE_W must be 8");
      end
      if (PAGE_MON == PAGE_USER) begin : g_page_same
         $error("mon_entry_ctrl: monitor and user pages must differ");
      end
   endgenerate

   logic [SYNC_W-1:0] raw, syn;
   logic s_rst, s_irq, s_rhv, s_mode;
   logic win_clr, win_run, win_done;
   logic in_mon, hv_entry, rhv_seen, fault;

   assign raw = {mode_pin, rst_hv, irq_hv, rst_pin_n};

   mon_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (SYNC_W),
      .RST_VAL ('0)
   ) u_sync (
      .clk (clk),
      .por (por),
      .d   (raw),
      .q   (syn)
   );

   assign s_rst  = syn[0];
   assign s_irq  = syn[1];
   assign s_rhv  = syn[2];
   assign s_mode = syn[3];

   mon_window_cnt #(
      .WIN_CYCLES (WIN_CYCLES)
   ) u_win (
      .clk  (clk),
      .por  (por),
      .clr  (win_clr),
      .run  (win_run),
      .done (win_done)
   );

   mon_entry_fsm u_fsm (
      .clk       (clk),
      .por       (por),
      .s_rst     (s_rst),
      .s_irq     (s_irq),
      .s_rhv     (s_rhv),
      .s_mode    (s_mode),
      .vec_blank (vec_blank),
      .win_done  (win_done),
      .win_clr   (win_clr),
      .win_run   (win_run),
      .in_mon    (in_mon),
      .hv_entry  (hv_entry),
      .rhv_seen  (rhv_seen),
      .fault     (fault)
   );

   assign mon_mode    = in_mon;
   assign cop_dis     = in_mon & hv_entry & (s_irq | rhv_seen);
   assign entry_fault = fault;
   assign vec_page    = in_mon ? PAGE_MON : PAGE_USER;

   // R9
   cop_mon_chk: assert property (@(posedge clk) disable iff (por)
      cop_dis |-> mon_mode);

   // R6
   page_mon_chk: assert property (@(posedge clk) disable iff (por)
      mon_mode |-> (vec_page == PAGE_MON));

   // R4
   fault_excl_chk: assert property (@(posedge clk) disable iff (por)
      entry_fault |-> !mon_mode);

   // R10
   cop_hold_chk: assert property (@(posedge clk) disable iff (por)
      (cop_dis && mon_mode && $stable(mon_mode) && rhv_seen) |=> (cop_dis || !mon_mode));

endmodule

// File: tb/tb_mon_entry_ctrl.sv
module tb_mon_entry_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 24;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic rst_pin_n = 1'b0;
   logic irq_hv = 1'b0;
   logic rst_hv = 1'b0;
   logic vec_blank = 1'b0;
   logic mode_pin = 1'b0;
   logic mon_mode, cop_dis, entry_fault;
   logic [7:0] vec_page;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mon_entry_ctrl dut (
      .clk         (clk),
      .por         (por),
      .rst_pin_n   (rst_pin_n),
      .irq_hv      (irq_hv),
      .rst_hv      (rst_hv),
      .vec_blank   (vec_blank),
      .mode_pin    (mode_pin),
      .mon_mode    (mon_mode),
      .cop_dis     (cop_dis),
      .entry_fault (entry_fault),
      .vec_page    (vec_page)
   );

   // behavioural reference: states 0 undecided, 1 user, 2 window, 3 monitor
   int m_st = 0, m_cnt = 0;
   bit m_hv, m_blank, m_rhv, m_fault, m_prev;
   bit q_rst[2], q_irq[2], q_rhv[2], q_mode[2];

   function automatic bit m_in_mon(int s);
      return (s == 2) || (s == 3);
   endfunction

   always @(posedge clk) begin
      if (por) begin
         m_st = 0; m_cnt = 0; m_hv = 0; m_blank = 0; m_rhv = 0; m_fault = 0; m_prev = 0;
         q_rst = '{0, 0}; q_irq = '{0, 0}; q_rhv = '{0, 0}; q_mode = '{0, 0};
      end else begin
         bit r, i, h, md, edge_seen, was_mon, old_hv;
         int nst;
         r = q_rst[1]; i = q_irq[1]; h = q_rhv[1]; md = q_mode[1];
         edge_seen = r && !m_prev;
         was_mon = m_in_mon(m_st);
         old_hv = m_hv;
         nst = m_st;
         if (!r && !(m_blank && was_mon)) begin
            nst = 0; m_hv = 0; m_blank = 0;
         end else if (m_st == 0) begin
            if (edge_seen) begin
               m_fault = 0;
               if (i || vec_blank) begin
                  if (md) begin nst = 1; m_fault = 1; end
                  else begin nst = 2; m_cnt = 0; m_hv = i; m_blank = !i; end
               end else nst = 1;
            end
         end else if (m_st == 2) begin
            if (md) begin nst = 1; m_fault = 1; m_hv = 0; m_blank = 0; end
            else if (m_cnt == WIN - 1) nst = 3;
            else m_cnt++;
         end
         if (!m_in_mon(nst)) m_rhv = 0;
         else if (was_mon && old_hv && h) m_rhv = 1;
         m_st = nst;
         m_prev = r;
         q_rst[1] = q_rst[0];   q_rst[0] = rst_pin_n;
         q_irq[1] = q_irq[0];   q_irq[0] = irq_hv;
         q_rhv[1] = q_rhv[0];   q_rhv[0] = rst_hv;
         q_mode[1] = q_mode[0]; q_mode[0] = mode_pin;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (!por && !finished) begin
         bit mm;
         mm = m_in_mon(m_st);
         chk("R3 mon_mode model", mon_mode, mm);
         chk("R6 vec_page model", vec_page, mm ? 8'hFE : 8'hFF);
         chk("R9 cop_dis model", cop_dis, mm && m_hv && (q_irq[1] || m_rhv));
         chk("R4 entry_fault model", entry_fault, m_fault);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_por();
      por = 1'b1;
      step(3);
      por = 1'b0;
      step(1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      // R1 reset state
      chk("R1 mon_mode in por", mon_mode, 0);
      chk("R1 vec_page in por", vec_page, 8'hFF);
      por = 1'b0;
      step(5);
      chk("R1 undecided mon_mode", mon_mode, 0);
      chk("R1 cop_dis", cop_dis, 0);
      chk("R1 entry_fault", entry_fault, 0);

      // high-voltage entry
      irq_hv = 1; rst_pin_n = 1;
      step(6);
      chk("R3 hv entry mon_mode", mon_mode, 1);
      chk("R6 page in window", vec_page, 8'hFE);
      chk("R9 cop_dis with irq hv", cop_dis, 1);
      step(WIN + 4);
      chk("R5 monitor after window", mon_mode, 1);
      chk("R5 no fault", entry_fault, 0);
      mode_pin = 1;
      step(6);
      chk("R5 mode pin ignored after window", mon_mode, 1);
      chk("R2 decision held", mon_mode, 1);
      mode_pin = 0;
      rst_hv = 1; step(4);
      irq_hv = 0; step(4);
      rst_hv = 0; step(4);
      chk("R10 cop_dis after irq hv removed", cop_dis, 1);
      rst_pin_n = 0; step(5);
      chk("R8 hv entry left by reset", mon_mode, 0);
      chk("R8 page back", vec_page, 8'hFF);

      // user mode
      rst_pin_n = 1; step(6);
      chk("R3 user mode", mon_mode, 0);
      vec_blank = 1; irq_hv = 1; step(6);
      chk("R2 late request ignored", mon_mode, 0);
      chk("R10 cop_dis in user", cop_dis, 0);
      vec_blank = 0;

      // fault inside window
      rst_pin_n = 0; step(4);
      rst_pin_n = 1; step(14);
      chk("R4 in window before rise", mon_mode, 1);
      mode_pin = 1; step(4);
      chk("R4 fault set", entry_fault, 1);
      chk("R4 user after fault", mon_mode, 0);
      mode_pin = 0; step(6);
      chk("R11 fault held", entry_fault, 1);

      // fault at decision edge
      rst_pin_n = 0; step(4);
      mode_pin = 1; rst_pin_n = 1; step(6);
      chk("R4 fault at edge", entry_fault, 1);
      mode_pin = 0;

      // clean re-entry clears fault
      rst_pin_n = 0; step(4);
      rst_pin_n = 1; step(6);
      chk("R11 fault cleared by decision", entry_fault, 0);
      chk("R3 re-entry", mon_mode, 1);
      irq_hv = 0;
      step(WIN + 4);

      // blank vector entry
      do_por();
      rst_pin_n = 0; vec_blank = 1; step(4);
      rst_pin_n = 1; step(6);
      chk("R3 blank entry", mon_mode, 1);
      chk("R10 no cop_dis on blank entry", cop_dis, 0);
      step(WIN + 4);
      rst_pin_n = 0; step(10);
      chk("R7 reset ignored", mon_mode, 1);
      rst_pin_n = 1; step(6);
      chk("R7 still monitor", mon_mode, 1);
      do_por();
      chk("R7 por clears", mon_mode, 0);
      chk("R1 page after por", vec_page, 8'hFF);

      // fault then por
      vec_blank = 0; irq_hv = 1; rst_pin_n = 0; step(3);
      mode_pin = 1; rst_pin_n = 1; step(6);
      chk("R4 fault before por", entry_fault, 1);
      do_por();
      chk("R11 por clears fault", entry_fault, 0);
      mode_pin = 0; irq_hv = 0;

      // window boundary: mode pin rises just after the window closes
      rst_pin_n = 0; step(3);
      irq_hv = 1; rst_pin_n = 1;
      step(WIN + 4);
      mode_pin = 1; step(4);
      chk("R5 rise after window", entry_fault, 0);
      mode_pin = 0;

      // mixed random phase, compared by the model each cycle
      for (int n = 0; n < 6000; n++) begin
         if ($urandom_range(0, 59) == 0) rst_pin_n = ~rst_pin_n;
         if ($urandom_range(0, 39) == 0) irq_hv = ~irq_hv;
         if ($urandom_range(0, 39) == 0) rst_hv = ~rst_hv;
         if ($urandom_range(0, 99) == 0) vec_blank = ~vec_blank;
         if ($urandom_range(0, 69) == 0) mode_pin = ~mode_pin;
         if ($urandom_range(0, 1999) == 0) do_por();
         step(1);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule